// File: doc/BRIEF.md
# Cascaded Interrupt Acknowledge and Vector Unit

This block joins two eight-line priority slices into a sixteen-line interrupt controller. Lines 0 to 7 enter the primary slice directly. Lines 8 to 15 enter the secondary slice. When the secondary slice holds a request that would win, that request is forwarded onto primary line 2 as an edge-style request. Each slice keeps its own request, in-service and edge-history registers, and its own rotating priority base. Edge or level detection is chosen per line by configuration inputs.

A single-cycle acknowledge strobe from the processor picks the winning line. The unit marks that line in service and drops its request if the line is edge-triggered. It then registers an 8-bit vector made of a five-bit base and the three-bit line number. An acknowledge on primary line 2 also acknowledges the secondary slice, and the vector then comes from the secondary base. When no real request is found, line 7 of the slice concerned is reported as a spurious vector. An automatic end-of-interrupt mode leaves nothing in service after the acknowledge, and it can also rotate the priority base. Two end-of-interrupt strobes, one per slice, retire the highest-priority in-service line.

Top module: `pic_cascade_ack`

## Requirements
- R1: During and right after synchronous reset, `int_out` is 0 and `vector` is 0, and every slice register is cleared. Both rotation bases are 0 after reset.
- R2: Each line has a trigger bit, where 1 means level and 0 means edge. A level line's request equals the input sampled at the last clock edge, and an acknowledge does not clear it. An edge line's request is set by a 0-to-1 change between two edge samples and stays set until that line is acknowledged. In an acknowledge cycle, the clear wins over a new edge on the same line.
- R3: `int_out` is a register. It is 1 in the cycle after the primary slice holds an unmasked request whose rank is better than that of its best in-service line. A request's rank is (line - base) mod 8, and 0 is the best. A mask bit of 1 hides its line from arbitration.
- R4: On an acknowledge that the primary slice wins with a line other than 2, `vector` becomes {`base_hi_m`, line} from the next cycle on. Line numbers occupy `vector[2:0]`.
- R5: A winning secondary request sets primary request bit 2 at the next edge. That bit is an edge request. An acknowledge won by primary line 2 also acknowledges the secondary winner, and `vector` becomes {`base_hi_s`, secondary line}.
- R6: If primary line 2 wins the acknowledge but the secondary slice has no winner, `vector` becomes {`base_hi_s`, 3'd7}, and no secondary state changes.
- R7: An acknowledge while the primary slice has no winner gives {`base_hi_m`, 3'd7} and changes no request or in-service bit.
- R8: When auto-EOI is off, an acknowledge sets the in-service bit of each acknowledged line. Equal or lower-ranked requests then keep `int_out` at 0 until that bit clears.
- R9: When `aeoi_en` is 1, an acknowledge leaves the acknowledged line out of service. If `rot_aeoi_en` is also 1, that slice's base becomes (line + 1) mod 8.
- R10: `eoi_m` and `eoi_s` each clear the best-ranked in-service bit of their own slice at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | 16 | Request lines; bits 7:0 primary, 15:8 secondary (primary bit 2 unused) |
| trig_level_m | input | 8 | Primary trigger select, 1 = level |
| trig_level_s | input | 8 | Secondary trigger select, 1 = level |
| mask_m | input | 8 | Primary mask, 1 = masked |
| mask_s | input | 8 | Secondary mask, 1 = masked |
| base_hi_m | input | 5 | Primary vector base, upper five bits |
| base_hi_s | input | 5 | Secondary vector base, upper five bits |
| aeoi_en | input | 1 | Automatic end-of-interrupt enable |
| rot_aeoi_en | input | 1 | Rotate on automatic end-of-interrupt |
| eoi_m | input | 1 | Primary end-of-interrupt strobe |
| eoi_s | input | 1 | Secondary end-of-interrupt strobe |
| ack | input | 1 | One-cycle acknowledge strobe |
| int_out | output | 1 | Registered interrupt request to the processor |
| vector | output | 8 | Registered vector of the last acknowledge |

## Verification
The assertions assume that the configuration inputs hold steady across an acknowledge. They also assume that the base fields are only read in the acknowledge cycle, so any value is legal there. No assumption is placed on how strobes line up with each other: an acknowledge, both end-of-interrupt strobes and line changes may land in the same cycle, and the stated orderings must then hold. The stimulus changes configuration only at phase boundaries. Within a phase it toggles lines, acknowledges and end-of-interrupts at random, so the overlapping cases occur without any special setup. Directed sections force the spurious-vector paths, the cascade path, nesting and rotation, and check fixed expected vectors.

// File: rtl/pic_cascade_pkg.sv
package pic_cascade_pkg;
  // which path produced the vector on an acknowledge
  typedef enum logic [1:0] {
    SRC_PRIMARY     = 2'd0,
    SRC_SECONDARY   = 2'd1,
    SRC_SEC_SPUR    = 2'd2,
    SRC_PRI_SPUR    = 2'd3
  } vec_src_t;
endpackage

// File: rtl/pic_rank.sv
// Rotating priority search: finds the set bit with the smallest
// (line - base) mod LINES. rank == LINES when nothing is set.
module pic_rank #(
  parameter int LINES = 8,
  localparam int IW = $clog2(LINES)
) (
  input  logic [LINES-1:0] bits,
  input  logic [IW-1:0]    base,
  output logic             found,
  output logic [IW-1:0]    line,
  output logic [IW:0]      rank
);
  always_comb begin
    found = 1'b0;
    line  = '0;
    rank  = (IW+1)'(LINES);
    for (int i = LINES - 1; i >= 0; i--) begin
      if (bits[base + IW'(i)]) begin
        found = 1'b1;
        line  = base + IW'(i);
        rank  = (IW+1)'(i);
      end
    end
  end
endmodule

// File: rtl/pic_slice.sv
// One eight-line priority slice: request, in-service, edge history and
// rotation base registers, with acknowledge and end-of-interrupt updates.
module pic_slice #(
  parameter int LINES = 8,
  localparam int IW = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] line_in,
  input  logic [LINES-1:0] level_mode,
  input  logic [LINES-1:0] force_set,
  input  logic [LINES-1:0] mask,
  input  logic             ack_go,
  input  logic             eoi,
  input  logic             aeoi_en,
  input  logic             rot_en,
  output logic             win_valid,
  output logic [IW-1:0]    win_line
);
  logic [LINES-1:0] irr_q, isr_q, last_q;
  logic [LINES-1:0] irr_d, isr_d, live_req;
  logic [IW-1:0]    base_q, base_d;
  logic             req_v, svc_v, take;
  logic [IW-1:0]    req_line, svc_line;
  logic [IW:0]      req_rank, svc_rank;

  assign live_req = irr_q & ~mask;

  pic_rank #(.LINES(LINES)) u_req_rank (
    .bits(live_req), .base(base_q),
    .found(req_v), .line(req_line), .rank(req_rank)
  );

  pic_rank #(.LINES(LINES)) u_svc_rank (
    .bits(isr_q), .base(base_q),
    .found(svc_v), .line(svc_line), .rank(svc_rank)
  );

  assign win_valid = req_v && (req_rank < svc_rank);
  assign win_line  = req_line;
  assign take      = ack_go && win_valid;

  always_comb begin
    irr_d = (level_mode & line_in)
          | (~level_mode & (irr_q | (line_in & ~last_q)))
          | force_set;
    if (take && !level_mode[win_line]) irr_d[win_line] = 1'b0;

    isr_d = isr_q;
    if (eoi && svc_v) isr_d[svc_line] = 1'b0;
    if (take && !aeoi_en) isr_d[win_line] = 1'b1;

    base_d = base_q;
    if (take && aeoi_en && rot_en) base_d = win_line + IW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irr_q  <= '0;
      isr_q  <= '0;
      last_q <= '0;
      base_q <= '0;
    end else begin
      irr_q  <= irr_d;
      isr_q  <= isr_d;
      last_q <= line_in;
      base_q <= base_d;
    end
  end

  // acknowledged line enters service when auto-EOI is off
  assert_ack_sets_service_R8: assert property (@(posedge clk) disable iff (rst)
    take && !aeoi_en |=> isr_q[$past(win_line)]);

  // acknowledged edge line loses its request, even with a new edge
  assert_edge_cleared_R2: assert property (@(posedge clk) disable iff (rst)
    take && !level_mode[win_line] |=> !irr_q[$past(win_line)]);

  // level lines mirror the sampled input
  assert_level_tracks_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((irr_q & $past(level_mode & ~force_set)) ==
              $past(line_in & level_mode & ~force_set)));

  // auto-EOI leaves nothing in service for the acknowledged line
  assert_aeoi_no_service_R9: assert property (@(posedge clk) disable iff (rst)
    take && aeoi_en |=> !isr_q[$past(win_line)]);
endmodule

// File: rtl/pic_cascade_ack.sv
module pic_cascade_ack
  import pic_cascade_pkg::*;
#(
  parameter int LINES     = 8,
  parameter int VEC_W     = 8,
  parameter int CASC_LINE = 2,
  localparam int IW       = $clog2(LINES),
  localparam int BASE_W   = VEC_W - IW
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [2*LINES-1:0] irq_lines,
  input  logic [LINES-1:0]   trig_level_m,
  input  logic [LINES-1:0]   trig_level_s,
  input  logic [LINES-1:0]   mask_m,
  input  logic [LINES-1:0]   mask_s,
  input  logic [BASE_W-1:0]  base_hi_m,
  input  logic [BASE_W-1:0]  base_hi_s,
  input  logic               aeoi_en,
  input  logic               rot_aeoi_en,
  input  logic               eoi_m,
  input  logic               eoi_s,
  input  logic               ack,
  output logic               int_out,
  output logic [VEC_W-1:0]   vector
);
  localparam logic [LINES-1:0] CASC_BIT = LINES'(1) << CASC_LINE;
  localparam logic [IW-1:0]    CASC_IDX = IW'(CASC_LINE);
  localparam logic [IW-1:0]    SPUR_IDX = IW'(LINES - 1);

  logic             m_win, s_win, s_ack_go;
  logic [IW-1:0]    m_line, s_line;
  logic [LINES-1:0] m_lines, m_level, m_force;
  logic [VEC_W-1:0] vec_d, vec_q;
  logic             int_q;
  vec_src_t         src;

  // primary cascade input is fed only by the secondary winner, as an edge
  assign m_lines  = irq_lines[LINES-1:0] & ~CASC_BIT;
  assign m_level  = trig_level_m & ~CASC_BIT;
  assign m_force  = s_win ? CASC_BIT : '0;
  assign s_ack_go = ack && m_win && (m_line == CASC_IDX);

  pic_slice #(.LINES(LINES)) u_primary (
    .clk(clk), .rst(rst),
    .line_in(m_lines), .level_mode(m_level), .force_set(m_force),
    .mask(mask_m), .ack_go(ack), .eoi(eoi_m),
    .aeoi_en(aeoi_en), .rot_en(rot_aeoi_en),
    .win_valid(m_win), .win_line(m_line)
  );

  pic_slice #(.LINES(LINES)) u_secondary (
    .clk(clk), .rst(rst),
    .line_in(irq_lines[2*LINES-1:LINES]), .level_mode(trig_level_s),
    .force_set('0), .mask(mask_s), .ack_go(s_ack_go), .eoi(eoi_s),
    .aeoi_en(aeoi_en), .rot_en(rot_aeoi_en),
    .win_valid(s_win), .win_line(s_line)
  );

  always_comb begin
    if (!m_win) begin
      src   = SRC_PRI_SPUR;
      vec_d = {base_hi_m, SPUR_IDX};
    end else if (m_line == CASC_IDX) begin
      if (s_win) begin
        src   = SRC_SECONDARY;
        vec_d = {base_hi_s, s_line};
      end else begin
        src   = SRC_SEC_SPUR;
        vec_d = {base_hi_s, SPUR_IDX};
      end
    end else begin
      src   = SRC_PRIMARY;
      vec_d = {base_hi_m, m_line};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      int_q <= 1'b0;
      vec_q <= '0;
    end else begin
      int_q <= m_win;
      if (ack) vec_q <= vec_d;
    end
  end

  assign int_out = int_q;
  assign vector  = vec_q;

  // output follows the primary winner with one register of delay
  assert_int_follows_R3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> int_out == $past(m_win));

  // no primary winner: primary base with line 7
  assert_primary_spurious_R7: assert property (@(posedge clk) disable iff (rst)
    ack && !m_win |=> vector == {$past(base_hi_m), SPUR_IDX});

  // cascade acknowledge carries the secondary line number
  assert_cascade_line_R5: assert property (@(posedge clk) disable iff (rst)
    ack && src == SRC_SECONDARY |=> vector[IW-1:0] == $past(s_line));

  // secondary spurious vector
  assert_secondary_spurious_R6: assert property (@(posedge clk) disable iff (rst)
    ack && src == SRC_SEC_SPUR |=> vector == {$past(base_hi_s), SPUR_IDX});
endmodule

// File: tb/pic_cascade_ack_tb_top.sv
module pic_cascade_ack_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] irq_lines = '0;
  logic [7:0]  trig_level_m = '0, trig_level_s = '0, mask_m = '0, mask_s = '0;
  logic [4:0]  base_hi_m = 5'h04, base_hi_s = 5'h05;
  logic        aeoi_en = 1'b0, rot_aeoi_en = 1'b0;
  logic        eoi_m = 1'b0, eoi_s = 1'b0, ack = 1'b0;
  logic        int_out;
  logic [7:0]  vector;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  pic_cascade_ack dut_i (
    .clk(clk), .rst(rst), .irq_lines(irq_lines),
    .trig_level_m(trig_level_m), .trig_level_s(trig_level_s),
    .mask_m(mask_m), .mask_s(mask_s),
    .base_hi_m(base_hi_m), .base_hi_s(base_hi_s),
    .aeoi_en(aeoi_en), .rot_aeoi_en(rot_aeoi_en),
    .eoi_m(eoi_m), .eoi_s(eoi_s), .ack(ack),
    .int_out(int_out), .vector(vector)
  );

  // reference model state: index 0 primary, 1 secondary
  logic [7:0] mirr [2];
  logic [7:0] misr [2];
  logic [7:0] mlast[2];
  logic [2:0] mbase[2];
  logic       exp_int;
  logic [7:0] exp_vec;
  string      vec_tag;

  function automatic int rank_of(input logic [7:0] b, input logic [2:0] base,
                                 output logic [2:0] ln);
    ln = 3'd0;
    for (int r = 0; r < 8; r++) begin
      logic [2:0] idx;
      idx = base + 3'(r);
      if (b[idx]) begin
        ln = idx;
        return r;
      end
    end
    return 8;
  endfunction

  task automatic slice_step(input int p, input logic [7:0] lines, lvl, frc,
                            input logic take, input logic [2:0] ln, input logic eo);
    logic [7:0] n;
    logic [2:0] sl;
    int sr;
    n = (lvl & lines) | (~lvl & (mirr[p] | (lines & ~mlast[p]))) | frc;
    if (take && !lvl[ln]) n[ln] = 1'b0;
    sr = rank_of(misr[p], mbase[p], sl);
    if (eo && sr < 8) misr[p][sl] = 1'b0;
    if (take && !aeoi_en) misr[p][ln] = 1'b1;
    if (take && aeoi_en && rot_aeoi_en) mbase[p] = ln + 3'd1;
    mirr[p]  = n;
    mlast[p] = lines;
  endtask

  task automatic model_clear();
    for (int p = 0; p < 2; p++) begin
      mirr[p] = '0; misr[p] = '0; mlast[p] = '0; mbase[p] = '0;
    end
    exp_int = 1'b0;
    exp_vec = '0;
  endtask

  task automatic model_step();
    logic [2:0] sl, ml, dummy;
    int sq, ss, mq, ms;
    logic s_win, m_win, take_m, take_s;
    sq = rank_of(mirr[1] & ~mask_s, mbase[1], sl);
    ss = rank_of(misr[1], mbase[1], dummy);
    s_win = (sq < 8) && (sq < ss);
    mq = rank_of(mirr[0] & ~mask_m, mbase[0], ml);
    ms = rank_of(misr[0], mbase[0], dummy);
    m_win = (mq < 8) && (mq < ms);
    exp_int = m_win;
    if (ack) begin
      if (!m_win) begin
        exp_vec = {base_hi_m, 3'd7}; vec_tag = "R7";
      end else if (ml == 3'd2) begin
        if (s_win) begin exp_vec = {base_hi_s, sl}; vec_tag = "R5"; end
        else begin exp_vec = {base_hi_s, 3'd7}; vec_tag = "R6"; end
      end else begin
        exp_vec = {base_hi_m, ml}; vec_tag = "R4";
      end
    end
    take_m = ack && m_win;
    take_s = take_m && (ml == 3'd2) && s_win;
    slice_step(1, irq_lines[15:8], trig_level_s, 8'h00, take_s, sl, eoi_s);
    slice_step(0, irq_lines[7:0] & 8'hFB, trig_level_m & 8'hFB,
               s_win ? 8'h04 : 8'h00, take_m, ml, eoi_m);
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  // called at a negative edge with irq/config already driven
  task automatic tick(input logic a, input logic em, input logic es);
    ack = a; eoi_m = em; eoi_s = es;
    model_step();
    @(posedge clk); #1;
    check("R3 int_out", {7'd0, int_out}, {7'd0, exp_int});
    if (a) check({vec_tag, " vector"}, vector, exp_vec);
    @(negedge clk);
    ack = 1'b0; eoi_m = 1'b0; eoi_s = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    irq_lines = '0;
    @(posedge clk); @(posedge clk); #1;
    check("R1 int_out in reset", {7'd0, int_out}, 8'd0);
    check("R1 vector in reset", vector, 8'd0);
    @(negedge clk);
    rst = 1'b0;
    model_clear();
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    do_reset();

    // R2 R4 R8 R10: edge request, nesting, end-of-interrupt
    irq_lines[3] = 1'b1;
    tick(0, 0, 0); tick(0, 0, 0);
    tick(1, 0, 0);
    check("R4 primary vector", vector, 8'h23);
    irq_lines[5] = 1'b1;
    tick(0, 0, 0); tick(0, 0, 0);
    check("R8 lower request held off", {7'd0, int_out}, 8'd0);
    tick(0, 1, 0); tick(0, 0, 0); tick(0, 0, 0);
    check("R10 int after eoi", {7'd0, int_out}, 8'd1);
    tick(1, 0, 0);
    check("R2 edge line not re-requested", vector, 8'h25);

    // R2 level line stays requested after acknowledge
    do_reset();
    trig_level_m = 8'h40;
    irq_lines[6] = 1'b1;
    tick(0, 0, 0); tick(0, 0, 0);
    tick(1, 0, 0);
    check("R4 level vector", vector, 8'h26);
    tick(0, 1, 0); tick(0, 0, 0); tick(0, 0, 0);
    check("R2 level request kept", {7'd0, int_out}, 8'd1);
    trig_level_m = 8'h00;

    // R3 masked line gives no interrupt
    do_reset();
    mask_m = 8'h08;
    irq_lines[3] = 1'b1;
    tick(0, 0, 0); tick(0, 0, 0); tick(0, 0, 0);
    check("R3 masked line", {7'd0, int_out}, 8'd0);
    mask_m = 8'h00;

    // R5 cascade acknowledge
    do_reset();
    irq_lines[12] = 1'b1;
    tick(0, 0, 0); tick(0, 0, 0); tick(0, 0, 0);
    tick(1, 0, 0);
    check("R5 cascade vector", vector, 8'h2C);

    // R6 secondary request vanishes before acknowledge
    do_reset();
    trig_level_s = 8'h02;
    irq_lines[9] = 1'b1;
    tick(0, 0, 0); tick(0, 0, 0); tick(0, 0, 0);
    irq_lines[9] = 1'b0;
    tick(0, 0, 0); tick(0, 0, 0);
    tick(1, 0, 0);
    check("R6 secondary spurious", vector, 8'h2F);
    trig_level_s = 8'h00;

    // R7 nothing pending
    do_reset();
    tick(1, 0, 0);
    check("R7 primary spurious", vector, 8'h27);
    tick(0, 0, 0);
    check("R7 no state change", {7'd0, int_out}, 8'd0);

    // R9 auto-EOI with rotation
    do_reset();
    aeoi_en = 1'b1; rot_aeoi_en = 1'b1;
    irq_lines[3] = 1'b1;
    tick(0, 0, 0); tick(0, 0, 0);
    tick(1, 0, 0);
    check("R9 aeoi vector", vector, 8'h23);
    irq_lines[1] = 1'b1; irq_lines[5] = 1'b1;
    tick(0, 0, 0); tick(0, 0, 0);
    check("R9 nothing left in service", {7'd0, int_out}, 8'd1);
    tick(1, 0, 0);
    check("R9 rotated priority", vector, 8'h25);
    aeoi_en = 1'b0; rot_aeoi_en = 1'b0;

    // random phases against the model
    do_reset();
    for (int ph = 0; ph < 8; ph++) begin
      trig_level_m = 8'($urandom);
      trig_level_s = 8'($urandom);
      mask_m       = 8'($urandom) & 8'($urandom) & 8'($urandom);
      mask_s       = 8'($urandom) & 8'($urandom) & 8'($urandom);
      base_hi_m    = 5'($urandom);
      base_hi_s    = 5'($urandom);
      aeoi_en      = 1'($urandom);
      rot_aeoi_en  = 1'($urandom);
      for (int c = 0; c < 2000; c++) begin
        for (int b = 0; b < 16; b++)
          if ($urandom_range(7) == 0) irq_lines[b] = ~irq_lines[b];
        tick($urandom_range(5) == 0, $urandom_range(9) == 0,
             $urandom_range(9) == 0);
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule